// File: doc/BRIEF.md
# Lockable Prescaled Watchdog Timer

This block is a supervision timer for a small processor subsystem. A 15-bit up-counter advances on ticks from a prescaler that divides the clock by 24 or by 384. When the counter wraps past its all-ones value, the block raises a one-cycle request for an internal synchronous reset. A system reset generator outside the block consumes this request.

The timer starts in one of two ways. Hardware can start it by holding a start input high while the external reset is asserted. Software can start it by setting an enable bit. Once the timer is running, nothing but the external reset stops it. Software keeps the timer from expiring by a two-write refresh. An arm write must be followed on the very next clock by a confirm write. The refresh loads the upper counter bits from a reload register, and it clears the lower counter bits and the prescaler. A sticky cause flag records that a watchdog overflow has taken place.

Software reaches the block through a small write port and a combinational read port, each with a 2-bit address.

Top module: `wdog_guard`

## Requirements
- R1: While `ext_rst_n` is low and at its release, the block is in its reset state. The counter, the prescaler, the reload register, the prescale select, the cause flag and `wd_rst_req` are all zero. The timer is not running unless `hw_start` was high during reset.
- R2: If `hw_start` is high while `ext_rst_n` is low, the timer is running after release. Status bit 0 reads 1, and counting begins on the first clock edge after release.
- R3: A write to address 0 with data bit 0 set starts a stopped timer. Status bit 0 (read address 0) reports the running state.
- R4: Once the timer is running, a write to address 0 with bit 0 clear leaves it running.
- R5: Bit 1 of a write to address 0 selects the prescaler division: 0 makes the counter advance once every 24 clocks, and 1 makes it advance once every 384 clocks. Status bit 1 reads the selection back.
- R6: A timer that is not running keeps its counter at its present value. Read address 2 returns counter bits 7:0, and read address 3 returns counter bits 14:8 in bits 6:0.
- R7: A write to address 2 (arm) followed on the next clock by a write to address 3 (confirm) refreshes the timer. The counter becomes the reload value shifted left by 8, and the prescaler restarts. The reload value is written at address 1, bits 6:0, and read back there.
- R8: A confirm write that does not directly follow an arm write changes neither the counter nor the prescaler.
- R9: On the tick that moves the counter from 0x7FFF, the counter wraps to 0 and `wd_rst_req` is high for exactly the next cycle.
- R10: A watchdog overflow sets status bit 2 (the cause flag). The flag stays set until `ext_rst_n` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| ext_rst_n | input | 1 | External synchronous reset, active low |
| hw_start | input | 1 | Start request sampled while reset is asserted |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 reload, 2 arm, 3 confirm |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address: 0 status, 1 reload, 2 count low, 3 count high |
| rd_data | output | 8 | Read data, combinational |
| wd_rst_req | output | 1 | One-cycle request for an internal reset on overflow |

## Verification
A wrong prescaler count or tick condition shows in the count bytes within one division period, 24 or 384 clocks, after a refresh. A faulty refresh or arm tracking shows on the count read on the cycle after the confirm write. A running flag that can be cleared shows on status bit 0 on the cycle after the offending control write. A mistimed overflow moves the one-cycle `wd_rst_req` pulse away from the exact clock at which the counter leaves 0x7FFF. A cause flag that is not sticky shows on status bit 2 on the cycle after that pulse.

// File: rtl/wdog_guard.sv
module wdog_guard #(
  parameter int CNT_W    = 15,
  parameter int RLD_W    = 7,
  parameter int DIV_FAST = 24,
  parameter int DIV_SLOW = 384
) (
  input  logic       clk,
  input  logic       ext_rst_n,
  input  logic       hw_start,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       wd_rst_req
);
  localparam int LOW_W = CNT_W - RLD_W;
  localparam int PS_W  = $clog2(DIV_SLOW);

  logic             run_q, sel_q, cause_q, arm_q;
  logic [RLD_W-1:0] reload_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PS_W-1:0]  presc_q;
  logic [PS_W-1:0]  div_last;
  logic             tick, refresh, wr_ctrl;

  assign div_last = sel_q ? PS_W'(DIV_SLOW - 1) : PS_W'(DIV_FAST - 1);
  assign tick     = run_q && (presc_q >= div_last);
  assign wr_ctrl  = wr_en && (wr_addr == 2'd0);
  assign refresh  = wr_en && (wr_addr == 2'd3) && arm_q;

  always_ff @(posedge clk) begin
    if (!ext_rst_n) begin
      run_q      <= hw_start;
      sel_q      <= 1'b0;
      cause_q    <= 1'b0;
      arm_q      <= 1'b0;
      reload_q   <= '0;
      cnt_q      <= '0;
      presc_q    <= '0;
      wd_rst_req <= 1'b0;
    end else begin
      arm_q      <= wr_en && (wr_addr == 2'd2);
      wd_rst_req <= tick && (&cnt_q) && !refresh;
      if (tick && (&cnt_q) && !refresh) cause_q <= 1'b1;
      if (wr_ctrl) begin
        run_q <= run_q | wr_data[0];
        sel_q <= wr_data[1];
      end
      if (wr_en && (wr_addr == 2'd1)) reload_q <= wr_data[RLD_W-1:0];
      if (refresh) begin
        cnt_q   <= {reload_q, {LOW_W{1'b0}}};
        presc_q <= '0;
      end else if (run_q) begin
        presc_q <= tick ? '0 : presc_q + 1'b1;
        if (tick) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = {5'b0, cause_q, sel_q, run_q};
      2'd1:    rd_data = 8'(reload_q);
      2'd2:    rd_data = cnt_q[7:0];
      default: rd_data = 8'(cnt_q[CNT_W-1:8]);
    endcase
  end
endmodule

// File: rtl/wdog_guard_chk.sv
module wdog_guard_chk #(
  parameter int CNT_W    = 15,
  parameter int RLD_W    = 7,
  parameter int DIV_SLOW = 384,
  parameter int PS_W     = 9
) (
  input logic             clk,
  input logic             ext_rst_n,
  input logic             wd_rst_req,
  input logic             run_q,
  input logic             cause_q,
  input logic             refresh,
  input logic [RLD_W-1:0] reload_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [PS_W-1:0]  presc_q
);
  // R4
  run_lock_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
    run_q |=> run_q);
  // R9
  req_pulse_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
    wd_rst_req |=> !wd_rst_req);
  // R9
  req_wrap_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
    wd_rst_req |-> (cnt_q == '0) && (presc_q == '0));
  // R10
  cause_sticky_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
    cause_q |=> cause_q);
  // R10
  cause_set_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
    wd_rst_req |-> cause_q);
  // R7
  refresh_load_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
    refresh |=> (cnt_q == {$past(reload_q), {(CNT_W-RLD_W){1'b0}}}) && (presc_q == '0));
  // R6
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
    (!run_q && !refresh) |=> $stable(cnt_q));
  // R5
  presc_range_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
    presc_q < PS_W'(DIV_SLOW));
endmodule

bind wdog_guard wdog_guard_chk #(
  .CNT_W(CNT_W), .RLD_W(RLD_W), .DIV_SLOW(DIV_SLOW), .PS_W(PS_W)
) chk_i (
  .clk(clk), .ext_rst_n(ext_rst_n), .wd_rst_req(wd_rst_req), .run_q(run_q),
  .cause_q(cause_q), .refresh(refresh), .reload_q(reload_q), .cnt_q(cnt_q),
  .presc_q(presc_q)
);

// File: tb/wdog_guard_tb.sv
module wdog_guard_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT = 200000;

  logic clk = 1'b0, ext_rst_n = 1'b0, hw_start = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic wd_rst_req;
  int compared = 0, mismatched = 0, cycles = 0;
  int unsigned seed_v;

  wdog_guard dut_i (.clk(clk), .ext_rst_n(ext_rst_n), .hw_start(hw_start),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .wd_rst_req(wd_rst_req));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > LIMIT) begin
      mismatched++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected <= %0d", cycles, LIMIT);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  function automatic int exp_count(int rld, int k, int dv);
    return ((rld << 8) + k / dv) & 32'h7FFF;
  endfunction

  task automatic check(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_edges(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output int v);
    rd_addr = a; #1; v = int'(rd_data);
  endtask

  task automatic read_cnt(output int v);
    int lo, hi;
    rd(2'd2, lo); rd(2'd3, hi);
    v = (hi << 8) | lo;
  endtask

  task automatic refresh();
    wr(2'd2, 8'h00);
    wr(2'd3, 8'h00);
  endtask

  task automatic do_reset(logic hs);
    @(negedge clk);
    ext_rst_n = 1'b0; hw_start = hs;
    wait_edges(3);
    ext_rst_n = 1'b1; hw_start = 1'b0;
  endtask

  initial begin
    int v, c;
    seed_v = $urandom(32'd1234);
    do_reset(1'b0);
    // R1 reset state
    rd(2'd0, v); check("R1 status", v, 0);
    rd(2'd1, v); check("R1 reload", v, 0);
    read_cnt(c); check("R1 count", c, 0);
    check("R1 req", int'(wd_rst_req), 0);
    // R6 stopped timer holds
    wait_edges(100);
    read_cnt(c); check("R6 stopped count", c, 0);
    // R8 lone confirm while stopped
    wr(2'd3, 8'h00);
    read_cnt(c); check("R8 lone confirm", c, 0);
    // R3 software start
    wr(2'd0, 8'h01);
    rd(2'd0, v); check("R3 running", v & 1, 1);
    wait_edges(47);
    read_cnt(c); check("R5 fast rate", c, 47 / 24);
    // R4 cannot stop
    wr(2'd0, 8'h00);
    rd(2'd0, v); check("R4 still running", v & 1, 1);

    for (int it = 0; it < 40; it++) begin
      int rld = int'($urandom_range(0, 126));
      int sel = int'($urandom_range(0, 1));
      int dv = sel ? 384 : 24;
      int k1 = int'($urandom_range(1, 700));
      int k2 = int'($urandom_range(0, 700));
      int k;
      wr(2'd0, 8'(sel * 2 + 1));
      wr(2'd1, 8'(rld));
      rd(2'd1, v); check("R7 reload readback", v, rld);
      rd(2'd0, v); check("R5 select readback", (v >> 1) & 1, sel);
      refresh();
      read_cnt(c); check("R7 refresh load", c, rld << 8);
      k = k1;
      wait_edges(k1);
      if (it % 2 == 0) begin
        wr(2'd2, 8'h00); wait_edges(1); wr(2'd3, 8'h00);
        k = k + 3;
        read_cnt(c); check("R8 gap confirm", c, exp_count(rld, k, dv));
      end else begin
        wr(2'd3, 8'h00);
        k = k + 1;
        read_cnt(c); check("R8 lone confirm", c, exp_count(rld, k, dv));
      end
      wait_edges(k2);
      k = k + k2;
      read_cnt(c); check(sel ? "R5 slow rate" : "R5 fast rate", c, exp_count(rld, k, dv));
    end

    // R9 overflow
    wr(2'd0, 8'h01);
    wr(2'd1, 8'h7F);
    refresh();
    wait_edges(256 * 24 - 1);
    read_cnt(c); check("R9 before wrap count", c, 16'h7FFF);
    check("R9 before wrap req", int'(wd_rst_req), 0);
    wait_edges(1);
    check("R9 req pulse", int'(wd_rst_req), 1);
    read_cnt(c); check("R9 wrapped count", c, 0);
    rd(2'd0, v); check("R10 cause set", (v >> 2) & 1, 1);
    wait_edges(1);
    check("R9 req single cycle", int'(wd_rst_req), 0);
    wait_edges(50);
    rd(2'd0, v); check("R10 cause sticky", (v >> 2) & 1, 1);
    rd(2'd0, v); check("R4 running after overflow", v & 1, 1);

    // R1 / R10 external reset clears
    do_reset(1'b0);
    rd(2'd0, v); check("R10 cause cleared", v, 0);
    read_cnt(c); check("R1 count after reset", c, 0);

    // R2 hardware start
    do_reset(1'b1);
    rd(2'd0, v); check("R2 hw running", v & 1, 1);
    wait_edges(48);
    read_cnt(c); check("R2 hw counting", c, 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule